// File: doc/BRIEF.md
# Forwarded Result Queue with Early Register Write

This block sits in the trailing core of a redundant pair of cores. The leading core sends selected instruction results across the interconnect, each labelled with the index of the instruction that produced it. The block keeps these results in arrival order. When the trailing core dispatches an instruction, the block compares the instruction's index with the oldest held result.

When the indices match, the block writes the held value into the instruction's destination physical register before the instruction executes, and it sets that register's ready bit. Dependent instructions can then issue at once. The instruction still executes normally and writes the same register a second time. The block remembers every value it wrote early. When the instruction completes, the block compares the real result with the remembered value and raises a flag for that index if they differ.

A held result whose index is older than the dispatching instruction can never be used, so the block drops it. A flush empties the block completely.

Top module: `fwd_result_queue`

## Requirements
- R1: After reset the queue is empty, `push_ready` is 1, and `ew_en`, `rdy_set_en` and `mm_valid` are 0.
- R2: A push is accepted when `push_valid` and `push_ready` are both 1. `push_ready` is 0 while DEPTH entries are held. A push offered while `push_ready` is 0 is dropped, and the block never holds more than DEPTH entries.
- R3: A dispatch is a hit when the oldest entry's index equals `disp_idx` and a tracking slot is free. On a hit, the cycle after dispatch shows `ew_en`=1, `ew_preg`=`disp_preg` and `ew_data`=the entry's value, and the entry is removed.
- R4: Each early write sets the ready bit in the same cycle: `rdy_set_en`=1 and `rdy_set_preg`=`ew_preg`.
- R5: A dispatch misses when the queue is empty or the oldest index is newer than `disp_idx`. A miss writes nothing and keeps the oldest entry.
- R6: An index a is older than an index b when (a−b), taken modulo 2^IDX_W and read as a signed number, is negative, so the comparison survives index wrap-around. If the oldest entry is older than `disp_idx`, the dispatch discards that one entry and writes nothing.
- R7: When `exec_valid` names a tracked index, the cycle after shows `mm_valid`=1 and `mm_idx`=`exec_idx` only if `exec_data` differs from the early-written value. In both cases the tracking slot is freed. A completion for an untracked index raises no flag.
- R8: At most TRACK early writes wait for their completion at the same time. A matching dispatch while all slots are busy is treated as a miss, and the entry is kept.
- R9: `flush` empties the queue and all tracking. Any push, dispatch or completion presented in the flush cycle has no effect, and no output pulses on the following cycle.
- R10: Entries are consumed in the order in which they were pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Clears all held entries and tracking |
| push_valid | input | 1 | A forwarded result is offered |
| push_idx | input | IDX_W | Instruction index of the offered result |
| push_data | input | DATA_W | Offered result value |
| push_ready | output | 1 | Space is available for a push |
| disp_valid | input | 1 | An instruction dispatches this cycle |
| disp_idx | input | IDX_W | Index of the dispatching instruction |
| disp_preg | input | PREG_W | Destination physical register of the dispatching instruction |
| ew_en | output | 1 | Early register-file write strobe |
| ew_preg | output | PREG_W | Early write register number |
| ew_data | output | DATA_W | Early write value |
| rdy_set_en | output | 1 | Sets a register's ready bit |
| rdy_set_preg | output | PREG_W | Register whose ready bit is set |
| exec_valid | input | 1 | An instruction completes execution |
| exec_idx | input | IDX_W | Index of the completing instruction |
| exec_data | input | DATA_W | Executed result value |
| mm_valid | output | 1 | Executed result differs from the early-written value |
| mm_idx | output | IDX_W | Index of the mismatching instruction |

## Verification
The bench keeps its own model of the queue and of the tracking list, and it compares every output on every cycle. It presses on these cases:
- A full queue, where a design that ignores backpressure would overwrite the oldest entry.
- A stale oldest entry, which a faulty design would either keep forever or write to the register file.
- A newer oldest entry, which a faulty design would consume on a miss.
- Indices that wrap past zero, where a plain unsigned comparison gives the wrong age.
- All tracking slots busy, where a faulty design would either lose an entry or write without tracking it.
- Matching and differing completion values, where a faulty design would raise a false mismatch flag or miss a real one.
- A flush that arrives together with other traffic, which a faulty design would let through.

// File: rtl/fwdq_pkg.sv
package fwdq_pkg;

    localparam int IDX_W  = 8;
    localparam int DATA_W = 32;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        idx_t  idx;
        data_t val;
    } fwd_entry_t;

    // a is older than b when the wrapped difference a-b is negative
    function automatic logic idx_older(input idx_t a, input idx_t b);
        idx_t diff;
        diff = a - b;
        return diff[IDX_W-1];
    endfunction

endpackage

// File: rtl/fwdq_fifo.sv
module fwdq_fifo
    import fwdq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       flush,
    input  logic       push,
    input  fwd_entry_t push_entry,
    input  logic       pop,
    output fwd_entry_t head,
    output logic       empty,
    output logic       full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    fwd_entry_t         store [DEPTH];
    logic [PTR_W-1:0]   rd_ptr, wr_ptr;
    logic [CNT_W-1:0]   cnt;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign empty = (cnt == '0);
    assign full  = (cnt == CNT_W'(DEPTH));
    assign head  = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) begin
                store[wr_ptr] <= push_entry;
                wr_ptr        <= step(wr_ptr);
            end
            if (pop)
                rd_ptr <= step(rd_ptr);
            if (push && !pop)
                cnt <= cnt + CNT_W'(1);
            else if (pop && !push)
                cnt <= cnt - CNT_W'(1);
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
        push |-> (!full || pop));

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

endmodule

// File: rtl/fwdq_track.sv
module fwdq_track
    import fwdq_pkg::*;
#(
    parameter int TRACK = 4
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  flush,
    input  logic  alloc,
    input  idx_t  alloc_idx,
    input  data_t alloc_val,
    input  logic  exec_valid,
    input  idx_t  exec_idx,
    input  data_t exec_data,
    output logic  room,
    output logic  mm_valid,
    output idx_t  mm_idx
);
    localparam int SEL_W = (TRACK > 1) ? $clog2(TRACK) : 1;

    logic [TRACK-1:0] busy;
    idx_t             t_idx [TRACK];
    data_t            t_val [TRACK];
    logic [SEL_W-1:0] free_sel, hit_sel;
    logic             hit_any;

    always_comb begin
        room     = 1'b0;
        free_sel = '0;
        hit_any  = 1'b0;
        hit_sel  = '0;
        for (int i = TRACK - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                room     = 1'b1;
                free_sel = SEL_W'(i);
            end
            if (busy[i] && t_idx[i] == exec_idx) begin
                hit_any = 1'b1;
                hit_sel = SEL_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            busy     <= '0;
            mm_valid <= 1'b0;
            mm_idx   <= '0;
        end else begin
            if (exec_valid && hit_any)
                busy[hit_sel] <= 1'b0;
            if (alloc) begin
                busy[free_sel]  <= 1'b1;
                t_idx[free_sel] <= alloc_idx;
                t_val[free_sel] <= alloc_val;
            end
            mm_valid <= exec_valid && hit_any && (t_val[hit_sel] != exec_data);
            mm_idx   <= exec_idx;
        end
    end

    assert_alloc_room_R8: assert property (@(posedge clk) disable iff (rst)
        alloc |-> room);

    assert_mm_cause_R7: assert property (@(posedge clk) disable iff (rst)
        mm_valid |-> $past(exec_valid));

endmodule

// File: rtl/fwd_result_queue.sv
module fwd_result_queue
    import fwdq_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int TRACK  = 4,
    parameter int PREG_W = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     flush,
    input  logic                     push_valid,
    input  logic [IDX_W-1:0]         push_idx,
    input  logic [DATA_W-1:0]        push_data,
    output logic                     push_ready,
    input  logic                     disp_valid,
    input  logic [IDX_W-1:0]         disp_idx,
    input  logic [PREG_W-1:0]        disp_preg,
    output logic                     ew_en,
    output logic [PREG_W-1:0]        ew_preg,
    output logic [DATA_W-1:0]        ew_data,
    output logic                     rdy_set_en,
    output logic [PREG_W-1:0]        rdy_set_preg,
    input  logic                     exec_valid,
    input  logic [IDX_W-1:0]         exec_idx,
    input  logic [DATA_W-1:0]        exec_data,
    output logic                     mm_valid,
    output logic [IDX_W-1:0]         mm_idx
);
    fwd_entry_t head, in_entry;
    logic       empty, full, room;
    logic       do_push, hit, stale, pop;

    assign in_entry   = '{idx: push_idx, val: push_data};
    assign push_ready = !full;
    assign do_push    = push_valid && !full && !flush;

    assign hit   = disp_valid && !flush && !empty && room && (head.idx == disp_idx);
    assign stale = disp_valid && !flush && !empty && idx_older(head.idx, disp_idx);
    assign pop   = hit || stale;

    fwdq_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst(rst), .flush(flush),
        .push(do_push), .push_entry(in_entry),
        .pop(pop), .head(head), .empty(empty), .full(full)
    );

    fwdq_track #(.TRACK(TRACK)) track_i (
        .clk(clk), .rst(rst), .flush(flush),
        .alloc(hit), .alloc_idx(head.idx), .alloc_val(head.val),
        .exec_valid(exec_valid && !flush), .exec_idx(exec_idx), .exec_data(exec_data),
        .room(room), .mm_valid(mm_valid), .mm_idx(mm_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ew_en        <= 1'b0;
            ew_preg      <= '0;
            ew_data      <= '0;
            rdy_set_en   <= 1'b0;
            rdy_set_preg <= '0;
        end else begin
            ew_en        <= hit;
            ew_preg      <= disp_preg;
            ew_data      <= head.val;
            rdy_set_en   <= hit;
            rdy_set_preg <= disp_preg;
        end
    end

    assert_ew_cause_R3: assert property (@(posedge clk) disable iff (rst)
        ew_en |-> $past(disp_valid) && !$past(flush));

    assert_rdy_pair_R4: assert property (@(posedge clk) disable iff (rst)
        ew_en |-> (rdy_set_en && rdy_set_preg == ew_preg));

    assert_miss_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        (disp_valid && !flush && !empty && !hit && !stale && !do_push) |=> $stable(head));

endmodule

// File: tb/fwd_result_queue_tb_top.sv
module fwd_result_queue_tb_top;
    import fwdq_pkg::*;

    localparam int DEPTH = 8;
    localparam int TRACK = 4;
    localparam int PREG_W = 6;

    logic clk = 1'b0, rst = 1'b1, flush = 1'b0;
    logic push_valid = 1'b0, disp_valid = 1'b0, exec_valid = 1'b0;
    idx_t push_idx = '0, disp_idx = '0, exec_idx = '0;
    data_t push_data = '0, exec_data = '0;
    logic [PREG_W-1:0] disp_preg = '0;
    logic push_ready, ew_en, rdy_set_en, mm_valid;
    logic [PREG_W-1:0] ew_preg, rdy_set_preg;
    data_t ew_data;
    idx_t mm_idx;

    int n_checks = 0, n_fail = 0;

    always #5 clk = ~clk;

    fwd_result_queue #(.DEPTH(DEPTH), .TRACK(TRACK), .PREG_W(PREG_W)) dut_i (
        .clk(clk), .rst(rst), .flush(flush),
        .push_valid(push_valid), .push_idx(push_idx), .push_data(push_data),
        .push_ready(push_ready),
        .disp_valid(disp_valid), .disp_idx(disp_idx), .disp_preg(disp_preg),
        .ew_en(ew_en), .ew_preg(ew_preg), .ew_data(ew_data),
        .rdy_set_en(rdy_set_en), .rdy_set_preg(rdy_set_preg),
        .exec_valid(exec_valid), .exec_idx(exec_idx), .exec_data(exec_data),
        .mm_valid(mm_valid), .mm_idx(mm_idx)
    );

    // reference model
    idx_t  q_idx[$];
    data_t q_val[$];
    idx_t  t_idx[$];
    data_t t_val[$];
    logic  e_ew = 0, e_mm = 0;
    logic [PREG_W-1:0] e_preg = '0;
    data_t e_data = '0;
    idx_t  e_mmidx = '0;

    always @(posedge clk) begin
        if (rst) begin
            q_idx.delete(); q_val.delete(); t_idx.delete(); t_val.delete();
            e_ew = 0; e_mm = 0;
        end else begin
            e_ew = 0; e_mm = 0;
            if (flush) begin
                q_idx.delete(); q_val.delete(); t_idx.delete(); t_val.delete();
            end else begin
                automatic int  qn = q_idx.size();
                automatic bit  tfree = (t_idx.size() < TRACK);
                if (exec_valid) begin
                    for (int j = 0; j < t_idx.size(); j++) begin
                        if (t_idx[j] == exec_idx) begin
                            if (t_val[j] != exec_data) begin
                                e_mm = 1; e_mmidx = exec_idx;
                            end
                            t_idx.delete(j); t_val.delete(j);
                            break;
                        end
                    end
                end
                if (disp_valid && qn > 0) begin
                    automatic idx_t d = q_idx[0] - disp_idx;
                    if (q_idx[0] == disp_idx && tfree) begin
                        e_ew = 1; e_preg = disp_preg; e_data = q_val[0];
                        t_idx.push_back(q_idx[0]); t_val.push_back(q_val[0]);
                        void'(q_idx.pop_front()); void'(q_val.pop_front());
                    end else if (d[IDX_W-1]) begin
                        void'(q_idx.pop_front()); void'(q_val.pop_front());
                    end
                end
                if (push_valid && qn < DEPTH) begin
                    q_idx.push_back(push_idx); q_val.push_back(push_data);
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            chk("R2", "push_ready", 64'(push_ready), 64'(q_idx.size() < DEPTH));
            chk("R3", "ew_en", 64'(ew_en), 64'(e_ew));
            chk("R4", "rdy_set_en", 64'(rdy_set_en), 64'(e_ew));
            if (e_ew) begin
                chk("R3", "ew_preg", 64'(ew_preg), 64'(e_preg));
                chk("R3", "ew_data", 64'(ew_data), 64'(e_data));
                chk("R4", "rdy_set_preg", 64'(rdy_set_preg), 64'(e_preg));
            end
            chk("R7", "mm_valid", 64'(mm_valid), 64'(e_mm));
            if (e_mm) chk("R7", "mm_idx", 64'(mm_idx), 64'(e_mmidx));
        end
    end

    function automatic data_t val_of(input idx_t i);
        return 32'hC0DE_0000 + 32'(i) * 32'd17;
    endfunction

    task automatic idle();
        @(negedge clk);
        push_valid = 0; disp_valid = 0; exec_valid = 0; flush = 0;
    endtask

    task automatic push(input idx_t i);
        @(negedge clk);
        push_valid = 1; push_idx = i; push_data = val_of(i);
        disp_valid = 0; exec_valid = 0; flush = 0;
    endtask

    task automatic disp(input idx_t i, input logic [PREG_W-1:0] p);
        @(negedge clk);
        disp_valid = 1; disp_idx = i; disp_preg = p;
        push_valid = 0; exec_valid = 0; flush = 0;
    endtask

    task automatic exec(input idx_t i, input data_t v);
        @(negedge clk);
        exec_valid = 1; exec_idx = i; exec_data = v;
        push_valid = 0; disp_valid = 0; flush = 0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        idx_t ctr;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1: reset state
        chk("R1", "push_ready", 64'(push_ready), 64'd1);
        chk("R1", "ew_en", 64'(ew_en), 64'd0);
        chk("R1", "mm_valid", 64'(mm_valid), 64'd0);

        // R3 R4 R7 R10: hits in order, matching and differing completions
        push(10); push(11); push(12); idle();
        disp(10, 6'd3); idle();
        exec(10, val_of(10)); idle();
        disp(11, 6'd4); idle();
        exec(11, val_of(11) ^ 32'h1); idle();
        exec(99, 32'h5); idle();
        // R6: stale head 12 discarded by dispatch 20; R5: empty miss
        disp(20, 6'd5); idle();
        disp(21, 6'd6); idle();
        // R5: newer head kept on miss, then hit
        push(30); disp(29, 6'd7); idle();
        disp(30, 6'd8); idle();
        exec(30, val_of(30));
        // R2: fill beyond depth with backpressure
        for (int k = 0; k < DEPTH + 3; k++) push(idx_t'(40 + k));
        idle();
        chk("R2", "push_ready full", 64'(push_ready), 64'd0);
        // R8: tracker fills, next match treated as miss
        for (int k = 0; k < TRACK + 1; k++) begin disp(idx_t'(40 + k), 6'(k)); idle(); end
        exec(40, val_of(40)); idle();
        disp(idx_t'(40 + TRACK), 6'd9); idle();
        // R9: flush with concurrent traffic
        @(negedge clk);
        flush = 1; push_valid = 1; push_idx = 77; push_data = val_of(77);
        disp_valid = 1; disp_idx = idx_t'(41 + TRACK); exec_valid = 1; exec_idx = 41; exec_data = 0;
        idle(); idle();
        chk("R9", "push_ready after flush", 64'(push_ready), 64'd1);
        disp(77, 6'd1); idle();
        // R6: wrap-around ages
        push(250); push(2); disp(3, 6'd2); idle();
        push(8); disp(254, 6'd2); idle();
        disp(2, 6'd11); idle();
        // mixed traffic
        @(negedge clk); flush = 1; idle();
        ctr = 100;
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            flush = 0;
            push_valid = $urandom_range(1) == 1; push_idx = ctr; push_data = val_of(ctr);
            if (push_valid && q_idx.size() < DEPTH) ctr = ctr + 1;
            disp_valid = $urandom_range(2) != 0;
            disp_idx = (q_idx.size() > 0) ? q_idx[0] + idx_t'($urandom_range(2)) - idx_t'(1) : ctr;
            disp_preg = 6'($urandom_range(63));
            exec_valid = (t_idx.size() > 0) && ($urandom_range(2) == 0);
            exec_idx = (t_idx.size() > 0) ? t_idx[0] : 8'd0;
            exec_data = val_of(exec_idx) ^ 32'($urandom_range(1));
        end
        idle(); idle();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule